// File: doc/BRIEF.md
# Serial Port FIFO and Interrupt Hub

This block sits between a host register port and the serial shifter of a synchronous serial port. It holds one transmit FIFO and one receive FIFO. From their fill levels it derives the status flags and the three interrupt request lines. The host writes transmit words and reads receive words through a small address-decoded port. The same port gives access to a control word and a status word. The shifter takes transmit words through a valid/pop pair and delivers received words through a push strobe.

Each FIFO has its own threshold field. The field is written as the wanted threshold minus one. The transmit side asks for service while its level is at or below the field value. The receive side asks for service while its level is above the field value. Each request reaches its interrupt line only when its enable bit is set.

A received word that arrives while the receive FIFO is full is dropped. It sets a sticky overrun flag, which drives its own interrupt line. A test-access mode lets the host both write and read one chosen FIFO. While that mode is on, the shifter is cut off from the chosen FIFO.

Top module: `serfifo_hub`

## Requirements
- R1: After reset the control word reads 0. Both FIFOs are empty. The status word reads 0x0009: bit 0 (transmit not full) and bit 3 (transmit request) are set. All three interrupt lines are low.
- R2: A host write to address 0 with test mode off appends the word to the transmit FIFO. `tx_valid` is high while that FIFO holds a word. `tx_data` shows the oldest word. Each `tx_pop` while valid removes it, so words leave in write order.
- R3: `rx_push` with test mode off appends `rx_data` to the receive FIFO. With test mode off, a host read of address 0 returns the oldest receive word and removes it in the same cycle.
- R4: The transmit request (status bit 3) is high when the transmit level is at or below control bits [5:2]. `irq_tx` equals that request ANDed with control bit 0.
- R5: The receive request (status bit 4) is high when the receive level is strictly above control bits [9:6]. `irq_rx` equals that request ANDed with control bit 1.
- R6: `rx_push` into a full receive FIFO discards the word and leaves the level at its depth. It sets overrun (status bit 5), which drives `irq_ovr`. The flag stays set until the host writes status address 2 with bit 5 set. If a set and a clear happen in the same cycle, the set wins.
- R7: Status bit 0 is transmit-not-full and status bit 1 is receive-not-empty. Neither one drives any interrupt line.
- R8: Status bit 2 (busy) is high while `shift_active` is high or the transmit FIFO holds a word.
- R9: With control bit 10 set and bit 11 clear, host writes and reads at address 0 both act on the transmit FIFO, and `tx_valid` stays low.
- R10: With control bits 10 and 11 both set, host writes at address 0 append to the receive FIFO and host reads pop it. `rx_push` is ignored and cannot set overrun.
- R11: A host write to a full transmit FIFO is dropped. The level stays at the depth, which reads in status bits [10:6]. The receive level reads in bits [15:11].
- R12: A data read from an empty FIFO returns 0 and changes no level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (pops on address 0) |
| host_addr | input | 2 | 0 data, 1 control, 2 status, 3 unused |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data for the current address, combinational |
| tx_valid | output | 1 | Transmit word available to the shifter |
| tx_data | output | DATA_W | Oldest transmit word |
| tx_pop | input | 1 | Shifter takes the transmit word |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_data | input | DATA_W | Received word |
| shift_active | input | 1 | Shifter is sending a character |
| irq_tx | output | 1 | Transmit level interrupt |
| irq_rx | output | 1 | Receive level interrupt |
| irq_ovr | output | 1 | Receive overrun interrupt |

## Verification
Data, flags and interrupt lines are combinational views of registered state. So any host or shifter strobe shows its effect on the outputs in the cycle right after the clock edge that samples it. The read data for a data pop is valid in the same cycle the strobe is presented. The bench drives its inputs just after each rising edge. Its behavioural model updates on that same edge. Every output is compared against the model before the next edge, so each result is checked in exactly the cycle it becomes due. Directed checks with literal values confirm the level boundaries, the overrun set/clear priority and both test modes.

// File: rtl/serfifo_pkg.sv
package serfifo_pkg;
   typedef enum logic [1:0] {
      ADR_DATA = 2'd0,
      ADR_CTRL = 2'd1,
      ADR_STAT = 2'd2,
      ADR_NONE = 2'd3
   } host_addr_e;

   // status word layout
   localparam int ST_TXNF = 0;
   localparam int ST_RXNE = 1;
   localparam int ST_BUSY = 2;
   localparam int ST_TXRQ = 3;
   localparam int ST_RXRQ = 4;
   localparam int ST_OVR  = 5;
   localparam int ST_LVL  = 6;

   // control word layout (thresholds follow from CT_THR)
   localparam int CT_TXIE = 0;
   localparam int CT_RXIE = 1;
   localparam int CT_THR  = 2;
endpackage

// File: rtl/serfifo_buf.sv
module serfifo_buf #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic [$clog2(DEPTH):0] level,
   output logic              full,
   output logic              empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              push_ok, pop_ok;

   assign full    = (level == CNT_W'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign dout    = mem[rd_ptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (push_ok && wr_ptr == PTR_W'(i)) mem[i] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         if (push_ok && !pop_ok)      level <= level + 1'b1;
         else if (pop_ok && !push_ok) level <= level - 1'b1;
      end
   end
endmodule

// File: rtl/serfifo_ctl.sv
module serfifo_ctl #(
   parameter int THR_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_wr,
   input  logic [2*THR_W+3:0] ctl_wdata,
   input  logic               ovr_set,
   input  logic               ovr_clr,
   output logic               tx_ie,
   output logic               rx_ie,
   output logic [THR_W-1:0]   tx_thr,
   output logic [THR_W-1:0]   rx_thr,
   output logic               test_en,
   output logic               test_sel,
   output logic               ovr
);
   import serfifo_pkg::*;
   localparam int RXT = CT_THR + THR_W;
   localparam int TEN = CT_THR + 2*THR_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_ie    <= 1'b0;
         rx_ie    <= 1'b0;
         tx_thr   <= '0;
         rx_thr   <= '0;
         test_en  <= 1'b0;
         test_sel <= 1'b0;
      end else if (ctl_wr) begin
         tx_ie    <= ctl_wdata[CT_TXIE];
         rx_ie    <= ctl_wdata[CT_RXIE];
         tx_thr   <= ctl_wdata[CT_THR +: THR_W];
         rx_thr   <= ctl_wdata[RXT +: THR_W];
         test_en  <= ctl_wdata[TEN];
         test_sel <= ctl_wdata[TEN+1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr <= 1'b0;
      else if (ovr_set) ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
   end
endmodule

// File: rtl/serfifo_req.sv
module serfifo_req #(
   parameter int THR_W   = 4,
   parameter bit RX_SIDE = 1'b0
) (
   input  logic [THR_W:0]   level,
   input  logic [THR_W-1:0] thr,
   input  logic             ie,
   output logic             req,
   output logic             irq
);
   if (RX_SIDE) begin : g_rx
      assign req = (level > {1'b0, thr});
   end else begin : g_tx
      assign req = (level <= {1'b0, thr});
   end
   assign irq = req & ie;
endmodule

// File: rtl/serfifo_hub.sv
module serfifo_hub #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_re,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_pop,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              shift_active,
   output logic              irq_tx,
   output logic              irq_rx,
   output logic              irq_ovr
);
   import serfifo_pkg::*;

   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;
   localparam int THR_W = PTR_W;
   localparam int CTL_W = 2*THR_W + 4;

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("serfifo_hub: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < ST_LVL + 2*CNT_W || DATA_W < CTL_W) begin : g_bad_width
      $error("serfifo_hub: DATA_W too narrow for status and control words");
   end

   logic              tx_ie, rx_ie, test_en, test_sel, ovr;
   logic [THR_W-1:0]  tx_thr, rx_thr;
   logic [CNT_W-1:0]  tx_level, rx_level;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic [DATA_W-1:0] tx_dout, rx_dout, rx_din;
   logic              test_tx, test_rx, dat_wr, dat_rd;
   logic              tx_push_i, tx_pop_i, rx_push_i, rx_pop_i, rx_push_sh;
   logic              tx_req, rx_req;
   logic [DATA_W-1:0] ctl_word, stat_word;

   assign test_tx    = test_en & ~test_sel;
   assign test_rx    = test_en & test_sel;
   assign dat_wr     = host_we & (host_addr == ADR_DATA);
   assign dat_rd     = host_re & (host_addr == ADR_DATA);

   assign tx_push_i  = dat_wr & ~test_rx;
   assign tx_pop_i   = (tx_pop & ~test_tx) | (dat_rd & test_tx);
   assign rx_push_sh = rx_push & ~test_rx;
   assign rx_push_i  = rx_push_sh | (dat_wr & test_rx);
   assign rx_din     = test_rx ? host_wdata : rx_data;
   assign rx_pop_i   = dat_rd & ~test_tx;

   serfifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txbuf (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push_i), .din(host_wdata), .pop(tx_pop_i), .dout(tx_dout),
      .level(tx_level), .full(tx_full), .empty(tx_empty)
   );

   serfifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxbuf (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push_i), .din(rx_din), .pop(rx_pop_i), .dout(rx_dout),
      .level(rx_level), .full(rx_full), .empty(rx_empty)
   );

   serfifo_ctl #(.THR_W(THR_W)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(host_we & (host_addr == ADR_CTRL)),
      .ctl_wdata(host_wdata[CTL_W-1:0]),
      .ovr_set(rx_push_sh & rx_full),
      .ovr_clr(host_we & (host_addr == ADR_STAT) & host_wdata[ST_OVR]),
      .tx_ie(tx_ie), .rx_ie(rx_ie), .tx_thr(tx_thr), .rx_thr(rx_thr),
      .test_en(test_en), .test_sel(test_sel), .ovr(ovr)
   );

   serfifo_req #(.THR_W(THR_W), .RX_SIDE(1'b0)) u_txreq (
      .level(tx_level), .thr(tx_thr), .ie(tx_ie), .req(tx_req), .irq(irq_tx)
   );

   serfifo_req #(.THR_W(THR_W), .RX_SIDE(1'b1)) u_rxreq (
      .level(rx_level), .thr(rx_thr), .ie(rx_ie), .req(rx_req), .irq(irq_rx)
   );

   assign irq_ovr  = ovr;
   assign tx_valid = ~tx_empty & ~test_tx;
   assign tx_data  = tx_dout;

   always_comb begin
      ctl_word = '0;
      ctl_word[CT_TXIE]                  = tx_ie;
      ctl_word[CT_RXIE]                  = rx_ie;
      ctl_word[CT_THR +: THR_W]          = tx_thr;
      ctl_word[CT_THR + THR_W +: THR_W]  = rx_thr;
      ctl_word[CT_THR + 2*THR_W]         = test_en;
      ctl_word[CT_THR + 2*THR_W + 1]     = test_sel;
   end

   always_comb begin
      stat_word = '0;
      stat_word[ST_TXNF]                 = ~tx_full;
      stat_word[ST_RXNE]                 = ~rx_empty;
      stat_word[ST_BUSY]                 = shift_active | ~tx_empty;
      stat_word[ST_TXRQ]                 = tx_req;
      stat_word[ST_RXRQ]                 = rx_req;
      stat_word[ST_OVR]                  = ovr;
      stat_word[ST_LVL +: CNT_W]         = tx_level;
      stat_word[ST_LVL + CNT_W +: CNT_W] = rx_level;
   end

   always_comb begin
      unique case (host_addr)
         ADR_DATA: begin
            if (test_tx) host_rdata = tx_empty ? '0 : tx_dout;
            else         host_rdata = rx_empty ? '0 : rx_dout;
         end
         ADR_CTRL: host_rdata = ctl_word;
         ADR_STAT: host_rdata = stat_word;
         default:  host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/serfifo_hub_chk.sv
module serfifo_hub_chk #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   parameter int THR_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic              host_re,
   input logic [1:0]        host_addr,
   input logic [DATA_W-1:0] host_wdata,
   input logic              tx_valid,
   input logic              rx_push,
   input logic              irq_tx,
   input logic              irq_rx,
   input logic              irq_ovr,
   input logic              tx_ie,
   input logic              rx_ie,
   input logic [THR_W-1:0]  tx_thr,
   input logic [THR_W-1:0]  rx_thr,
   input logic              test_en,
   input logic              test_sel,
   input logic [THR_W:0]    tx_level,
   input logic [THR_W:0]    rx_level
);
   logic sh_push_full, ovr_clear, host_rx_pop;
   assign sh_push_full = rx_push && !(test_en && test_sel) && (rx_level == (THR_W+1)'(DEPTH));
   assign ovr_clear    = host_we && host_addr == 2'd2 && host_wdata[5];
   assign host_rx_pop  = host_re && host_addr == 2'd0;

   a_r4_irq_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx |-> (tx_ie && tx_level <= {1'b0, tx_thr}));

   a_r5_irq_rx_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |-> (rx_ie && rx_level > {1'b0, rx_thr}));

   a_r6_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
      sh_push_full |=> irq_ovr);

   a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ovr && !ovr_clear) |=> irq_ovr);

   a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_push_full && !host_rx_pop) |=> rx_level == (THR_W+1)'(DEPTH));

   a_r9_test_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && !test_sel) |-> !tx_valid);

   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= (THR_W+1)'(DEPTH) && rx_level <= (THR_W+1)'(DEPTH));
endmodule

bind serfifo_hub serfifo_hub_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THR_W(THR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
   .host_addr(host_addr), .host_wdata(host_wdata), .tx_valid(tx_valid),
   .rx_push(rx_push), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr),
   .tx_ie(tx_ie), .rx_ie(rx_ie), .tx_thr(tx_thr), .rx_thr(rx_thr),
   .test_en(test_en), .test_sel(test_sel),
   .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/serfifo_hub_bench.sv
module serfifo_hub_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_we = 0, host_re = 0;
   logic [1:0]    host_addr = 2'd2;
   logic [DW-1:0] host_wdata = '0;
   logic [DW-1:0] host_rdata;
   logic          tx_valid;
   logic [DW-1:0] tx_data;
   logic          tx_pop = 0, rx_push = 0, shift_active = 0;
   logic [DW-1:0] rx_data = '0;
   logic          irq_tx, irq_rx, irq_ovr;

   int checks = 0;
   int fails = 0;
   logic [DW-1:0] last_rd;

   // reference model state
   int   txq[$];
   int   rxq[$];
   logic m_txie, m_rxie, m_ten, m_tsel, m_ovr;
   int   m_txthr, m_rxthr;
   logic b_ttx, b_trx, b_dwr, b_drd, b_set;
   int   b_tn, b_rn;

   always #(CLK_PERIOD/2) clk = ~clk;

   serfifo_hub #(.DATA_W(DW), .DEPTH(DEPTH)) u_serfifo_hub (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_data(rx_data), .shift_active(shift_active),
      .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         m_txie = 0; m_rxie = 0; m_ten = 0; m_tsel = 0; m_ovr = 0;
         m_txthr = 0; m_rxthr = 0;
      end else begin
         b_ttx = m_ten && !m_tsel;
         b_trx = m_ten && m_tsel;
         b_dwr = host_we && host_addr == 2'd0;
         b_drd = host_re && host_addr == 2'd0;
         b_tn  = txq.size();
         b_rn  = rxq.size();
         b_set = 0;
         if (((tx_pop && !b_ttx) || (b_drd && b_ttx)) && b_tn > 0) void'(txq.pop_front());
         if (b_dwr && !b_trx && b_tn < DEPTH) txq.push_back(int'(host_wdata));
         if (b_drd && !b_ttx && b_rn > 0) void'(rxq.pop_front());
         if (rx_push && !b_trx) begin
            if (b_rn < DEPTH) rxq.push_back(int'(rx_data));
            else b_set = 1;
         end
         if (b_dwr && b_trx && b_rn < DEPTH) rxq.push_back(int'(host_wdata));
         if (b_set) m_ovr = 1;
         else if (host_we && host_addr == 2'd2 && host_wdata[5]) m_ovr = 0;
         if (host_we && host_addr == 2'd1) begin
            m_txie  = host_wdata[0];
            m_rxie  = host_wdata[1];
            m_txthr = int'(host_wdata[5:2]);
            m_rxthr = int'(host_wdata[9:6]);
            m_ten   = host_wdata[10];
            m_tsel  = host_wdata[11];
         end
      end
   end

   function automatic logic [DW-1:0] exp_rdata();
      logic [DW-1:0] s;
      case (host_addr)
         2'd0: begin
            if (m_ten && !m_tsel) return (txq.size() > 0) ? DW'(txq[0]) : '0;
            return (rxq.size() > 0) ? DW'(rxq[0]) : '0;
         end
         2'd1: return DW'({m_tsel, m_ten, 4'(m_rxthr), 4'(m_txthr), m_rxie, m_txie});
         2'd2: begin
            s = '0;
            s[0] = txq.size() < DEPTH;
            s[1] = rxq.size() > 0;
            s[2] = shift_active || txq.size() > 0;
            s[3] = txq.size() <= m_txthr;
            s[4] = rxq.size() > m_rxthr;
            s[5] = m_ovr;
            s[10:6]  = 5'(txq.size());
            s[15:11] = 5'(rxq.size());
            return s;
         end
         default: return '0;
      endcase
   endfunction

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare all outputs with the model, then advance one clock
   task automatic step();
      logic exp_txv;
      #1;
      exp_txv = txq.size() > 0 && !(m_ten && !m_tsel);
      check("R2 tx_valid", DW'(tx_valid), DW'(exp_txv));
      if (exp_txv) check("R2 tx_data", tx_data, DW'(txq[0]));
      check("R4 irq_tx", DW'(irq_tx), DW'(m_txie && txq.size() <= m_txthr));
      check("R5 irq_rx", DW'(irq_rx), DW'(m_rxie && rxq.size() > m_rxthr));
      check("R6 irq_ovr", DW'(irq_ovr), DW'(m_ovr));
      check("R3 host_rdata", host_rdata, exp_rdata());
      last_rd = host_rdata;
      @(posedge clk);
      #1;
      host_we = 0; host_re = 0; host_addr = 2'd2;
      tx_pop = 0; rx_push = 0;
   endtask

   task automatic hwr(logic [1:0] a, logic [DW-1:0] d);
      host_we = 1; host_addr = a; host_wdata = d; step();
   endtask

   task automatic hrd();
      host_re = 1; host_addr = 2'd0; step();
   endtask

   task automatic spush(logic [DW-1:0] d);
      rx_push = 1; rx_data = d; step();
   endtask

   task automatic spop();
      tx_pop = 1; step();
   endtask

   task automatic peek_stat();
      host_addr = 2'd2; step();
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      peek_stat();
      check("R1 status after reset", last_rd, 16'h0009);
      host_addr = 2'd1; step();
      check("R1 control after reset", last_rd, 16'h0000);
      check("R1 irq lines", DW'({irq_tx, irq_rx, irq_ovr}), '0);

      // R4 threshold 3, enable transmit interrupt
      hwr(2'd1, 16'h000D);
      for (int i = 0; i < 3; i++) hwr(2'd0, 16'hA000 + 16'(i));
      check("R4 irq_tx at level 3", DW'(irq_tx), 1);
      hwr(2'd0, 16'hA003);
      check("R4 irq_tx at level 4", DW'(irq_tx), 0);
      // R8 busy from non-empty FIFO
      peek_stat();
      check("R8 busy with data", DW'(last_rd[2]), 1);
      // R2 order at the shifter
      for (int i = 0; i < 4; i++) begin
         #1 check("R2 order", tx_data, 16'hA000 + 16'(i));
         spop();
      end
      check("R2 valid drops when empty", DW'(tx_valid), 0);
      shift_active = 1;
      peek_stat();
      check("R8 busy from shifter", DW'(last_rd[2]), 1);
      shift_active = 0;
      peek_stat();
      check("R8 idle", DW'(last_rd[2]), 0);

      // R5 receive threshold field 1 -> request above 1
      hwr(2'd1, 16'h0042);
      spush(16'h5501);
      check("R5 irq_rx at level 1", DW'(irq_rx), 0);
      spush(16'h5502);
      check("R5 irq_rx at level 2", DW'(irq_rx), 1);
      check("R7 flags raise no overrun", DW'(irq_ovr), 0);
      hrd();
      check("R3 first word", last_rd, 16'h5501);
      hrd();
      check("R3 second word", last_rd, 16'h5502);
      hrd();
      check("R12 empty read", last_rd, 16'h0000);
      peek_stat();
      check("R12 levels unchanged", last_rd[15:6], 10'h0);

      // R6 overrun
      hwr(2'd1, 16'h0000);
      for (int i = 0; i < DEPTH; i++) spush(16'h7000 + 16'(i));
      spush(16'hDEAD);
      check("R6 overrun set", DW'(irq_ovr), 1);
      peek_stat();
      check("R6 level held at depth", DW'(last_rd[15:11]), DW'(DEPTH));
      check("R7 rx not empty", DW'(last_rd[1]), 1);
      hrd();
      check("R6 oldest kept", last_rd, 16'h7000);
      hwr(2'd2, 16'h0020);
      check("R6 cleared by write", DW'(irq_ovr), 0);
      rx_push = 1; rx_data = 16'h1111; step();
      rx_push = 1; rx_data = 16'h2222;
      host_we = 1; host_addr = 2'd2; host_wdata = 16'h0020; step();
      check("R6 set wins over clear", DW'(irq_ovr), 1);
      hwr(2'd2, 16'h0020);
      for (int i = 0; i < DEPTH; i++) hrd();

      // R11 transmit full
      for (int i = 0; i < DEPTH + 1; i++) hwr(2'd0, 16'hB000 + 16'(i));
      peek_stat();
      check("R11 tx level at depth", DW'(last_rd[10:6]), DW'(DEPTH));
      check("R7 tx not full low", DW'(last_rd[0]), 0);
      for (int i = 0; i < DEPTH; i++) spop();

      // R9 test mode on transmit FIFO
      hwr(2'd1, 16'h0400);
      hwr(2'd0, 16'hC0DE);
      check("R9 tx_valid blocked", DW'(tx_valid), 0);
      spop();
      hrd();
      check("R9 read back transmit", last_rd, 16'hC0DE);

      // R10 test mode on receive FIFO
      hwr(2'd1, 16'h0C00);
      hwr(2'd0, 16'hBEEF);
      for (int i = 0; i < DEPTH; i++) spush(16'h0BAD);
      peek_stat();
      check("R10 shifter push ignored", DW'(last_rd[15:11]), 1);
      check("R10 no overrun", DW'(irq_ovr), 0);
      hrd();
      check("R10 read back receive", last_rd, 16'hBEEF);
      hwr(2'd1, 16'h0000);
      peek_stat();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule